// File: doc/BRIEF.md
# Fatal Bus Error Shutdown Controller

This block sits beside a bus master/slave interface. It turns any of four fatal bus error pulses into a sticky halted state. The pulses are a master abort, a target abort, an address parity error and a data parity error. Each error latches its own status bit. The first error raises a DMA stop and takes the receiver off line. A transmit frame that is already running is allowed to finish, but the block tells the transmit MAC to spoil the frame check sequence, so the corrupted data is never accepted downstream.

Software polls the two idle flags until both the transmitter and the receiver are quiet, then writes the soft reset bit. A soft reset clears every status bit, releases the DMA stop and puts the receiver back on line, all on the same clock edge.

Top module: `fatal_err_shutdown`

## Requirements
- R1: `err_pulse_i` bit 0 is master abort, bit 1 target abort, bit 2 address parity error and bit 3 data parity error. A pulse on bit n sets `err_stat_o` bit n on the next rising clock edge.
- R2: Status bits are sticky. A later pulse ORs a further bit into `err_stat_o` and leaves the bits already set in place.
- R3: On the edge that follows any error pulse, `dma_halt_o` and `rx_offline_o` both go high.
- R4: Once high, `dma_halt_o` and `rx_offline_o` stay high, with no input other than soft reset able to lower them. This holds even when no further errors arrive.
- R5: `tx_bad_crc_o` is high exactly when the block is halted and `tx_busy_i` is high, in the same cycle.
- R6: `tx_idle_o` is the inverse of `tx_busy_i`, in the same cycle.
- R7: `rx_idle_o` is high exactly when the receiver is off line and `rx_busy_i` is low.
- R8: A high `soft_rst_i` at a rising edge has the following effects on that edge:
  - it clears `err_stat_o`;
  - it lowers `dma_halt_o` and `rx_offline_o`;
  - it takes priority over any error pulse present in the same cycle.
- R9: While `rst_n` is low, all status bits and the halt are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse_i | input | 4 | Fatal error pulses (bit map in R1) |
| tx_busy_i | input | 1 | A transmit frame is in progress |
| rx_busy_i | input | 1 | A receive frame is in progress |
| soft_rst_i | input | 1 | Soft reset register bit |
| err_stat_o | output | 4 | Latched error status bits |
| dma_halt_o | output | 1 | Stop all DMA activity |
| rx_offline_o | output | 1 | Receiver taken off line |
| tx_bad_crc_o | output | 1 | Append a corrupted CRC to the current frame |
| tx_idle_o | output | 1 | No transmit frame in progress |
| rx_idle_o | output | 1 | Receiver off line and quiet |

## Verification
The status bits, the DMA stop and the off-line flag each pass through one register. They are therefore due one rising edge after the error pulse or soft reset that causes them. The bad-CRC and idle flags are combinational on that registered state and on the live busy inputs. The bench applies each input vector on a falling edge and holds it across the next rising edge. It then samples on the following falling edge, so that the registered results and the same-cycle flags are read together. Directed cases hold the block idle for many cycles to check stickiness, and they apply a soft reset together with a full set of error pulses.

// File: rtl/fes_pkg.sv
package fes_pkg;
   localparam int unsigned FES_NUM_ERR = 4;

   typedef enum logic [1:0] {
      FES_MASTER_ABORT = 2'd0,
      FES_TARGET_ABORT = 2'd1,
      FES_ADDR_PARITY  = 2'd2,
      FES_DATA_PARITY  = 2'd3
   } fes_err_idx_e;
endpackage

// File: rtl/fes_err_latch.sv
module fes_err_latch #(
   parameter int unsigned N_ERR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_ERR-1:0] pulse,
   output logic [N_ERR-1:0] stat
);
   generate
      if (N_ERR < 1) begin : g_bad_width
         $error("fes_err_latch: N_ERR must be at least 1");
      end
   endgenerate

   for (genvar gi = 0; gi < N_ERR; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         stat[gi] <= 1'b0;
         else if (clr)       stat[gi] <= 1'b0;
         else if (pulse[gi]) stat[gi] <= 1'b1;
      end

      // R2
      sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[gi] && !clr) |=> stat[gi]);

      // R1
      bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pulse[gi] && !clr) |=> stat[gi]);
   end
endmodule

// File: rtl/fes_halt_ctrl.sv
module fes_halt_ctrl #(
   parameter int unsigned N_ERR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_ERR-1:0] pulse,
   input  logic [N_ERR-1:0] stat,
   output logic             halt_q
);
   logic trip;
   assign trip = |pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    halt_q <= 1'b0;
      else if (clr)  halt_q <= 1'b0;
      else if (trip) halt_q <= 1'b1;
   end

   // R4
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !clr) |=> halt_q);

   // R3
   halt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> (stat != '0));

   // R8
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!halt_q && stat == '0));
endmodule

// File: rtl/fatal_err_shutdown.sv
module fatal_err_shutdown
   import fes_pkg::*;
#(
   parameter int unsigned N_ERR = FES_NUM_ERR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_ERR-1:0] err_pulse_i,
   input  logic             tx_busy_i,
   input  logic             rx_busy_i,
   input  logic             soft_rst_i,
   output logic [N_ERR-1:0] err_stat_o,
   output logic             dma_halt_o,
   output logic             rx_offline_o,
   output logic             tx_bad_crc_o,
   output logic             tx_idle_o,
   output logic             rx_idle_o
);
   logic halt_q;

   fes_err_latch #(.N_ERR(N_ERR)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst_i),
      .pulse (err_pulse_i),
      .stat  (err_stat_o)
   );

   fes_halt_ctrl #(.N_ERR(N_ERR)) u_halt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst_i),
      .pulse  (err_pulse_i),
      .stat   (err_stat_o),
      .halt_q (halt_q)
   );

   assign dma_halt_o   = halt_q;
   assign rx_offline_o = halt_q;
   assign tx_bad_crc_o = halt_q & tx_busy_i;
   assign tx_idle_o    = ~tx_busy_i;
   assign rx_idle_o    = halt_q & ~rx_busy_i;

   // R5
   bad_crc_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bad_crc_o |-> (!tx_idle_o && dma_halt_o));

   // R7
   rx_idle_offline_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_idle_o |-> rx_offline_o);
endmodule

// File: tb/sim_fatal_err_shutdown.sv
`timescale 1ns/1ps
module sim_fatal_err_shutdown;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] err_pulse_i = '0;
   logic       tx_busy_i = 1'b0, rx_busy_i = 1'b0, soft_rst_i = 1'b0;
   logic [3:0] err_stat_o;
   logic       dma_halt_o, rx_offline_o, tx_bad_crc_o, tx_idle_o, rx_idle_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fatal_err_shutdown u0 (
      .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse_i),
      .tx_busy_i(tx_busy_i), .rx_busy_i(rx_busy_i), .soft_rst_i(soft_rst_i),
      .err_stat_o(err_stat_o), .dma_halt_o(dma_halt_o), .rx_offline_o(rx_offline_o),
      .tx_bad_crc_o(tx_bad_crc_o), .tx_idle_o(tx_idle_o), .rx_idle_o(rx_idle_o)
   );

   typedef struct packed {
      logic [3:0] pulse;
      logic       tx, rx, sr;
      logic [3:0] e_stat;
      logic       e_halt, e_bad, e_txi, e_rxi;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
      '{4'b0001, 1'b1, 1'b1, 1'b0, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0},
      '{4'b0100, 1'b1, 1'b1, 1'b0, 4'b0101, 1'b1, 1'b1, 1'b0, 1'b0},
      '{4'b0000, 1'b0, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b1, 1'b1},
      '{4'b0000, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
      '{4'b0010, 1'b0, 1'b1, 1'b0, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b0},
      '{4'b1000, 1'b0, 1'b0, 1'b0, 4'b1010, 1'b1, 1'b0, 1'b1, 1'b1},
      '{4'b1111, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
      '{4'b1000, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b1},
      '{4'b0000, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] p, input logic tx, input logic rx, input logic sr);
      @(negedge clk);
      err_pulse_i = p; tx_busy_i = tx; rx_busy_i = rx; soft_rst_i = sr;
      @(negedge clk);
   endtask

   task automatic check_vec(input vec_t v, input int idx);
      chk($sformatf("R1 R2 R8 stat vec%0d", idx), {4'b0, err_stat_o}, {4'b0, v.e_stat});
      chk($sformatf("R3 R4 halt vec%0d", idx), {6'b0, dma_halt_o, rx_offline_o}, {6'b0, v.e_halt, v.e_halt});
      chk($sformatf("R5 badcrc vec%0d", idx), {7'b0, tx_bad_crc_o}, {7'b0, v.e_bad});
      chk($sformatf("R6 txidle vec%0d", idx), {7'b0, tx_idle_o}, {7'b0, v.e_txi});
      chk($sformatf("R7 rxidle vec%0d", idx), {7'b0, rx_idle_o}, {7'b0, v.e_rxi});
   endtask

   initial begin
      // R9: reset state, with an error pulse held during reset
      err_pulse_i = 4'b1111;
      repeat (3) @(negedge clk);
      chk("R9 reset stat", {4'b0, err_stat_o}, 8'h00);
      chk("R9 reset halt", {6'b0, dma_halt_o, rx_offline_o}, 8'h00);
      err_pulse_i = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].pulse, VECS[i].tx, VECS[i].rx, VECS[i].sr);
         check_vec(VECS[i], i);
      end

      // R4: halt and status persist over a long quiet stretch
      apply(4'b0100, 1'b0, 1'b0, 1'b0);
      apply(4'b0000, 1'b0, 1'b0, 1'b0);
      repeat (50) @(negedge clk);
      chk("R4 held halt", {6'b0, dma_halt_o, rx_offline_o}, 8'h03);
      chk("R2 held stat", {4'b0, err_stat_o}, 8'h04);

      // R1: each error bit on its own, from a clean state
      for (int b = 0; b < 4; b++) begin
         apply(4'b0000, 1'b0, 1'b0, 1'b1);
         apply(4'b0001 << b, 1'b0, 1'b0, 1'b0);
         chk($sformatf("R1 single bit %0d", b), {4'b0, err_stat_o}, {4'b0, 4'b0001 << b});
      end

      // R8: soft reset, then normal operation with no halt
      apply(4'b0000, 1'b0, 1'b0, 1'b1);
      apply(4'b0000, 1'b1, 1'b1, 1'b0);
      chk("R8 resumed halt", {6'b0, dma_halt_o, rx_offline_o}, 8'h00);
      chk("R5 no badcrc when running", {7'b0, tx_bad_crc_o}, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule